// File: doc/BRIEF.md
# FIFO DMA Single-Transfer Requester

This block sits between the transmit and receive FIFOs of an audio serial port and a DMA controller. It decides when to ask the DMA controller for service. It then carries out exactly one FIFO access for each request the controller acknowledges. The transmit side asks for a word whenever its FIFO has room. The receive side asks whenever its FIFO holds data. Each direction has its own enable bit, and software can stop a direction by clearing that bit.

The FIFO storage lives outside the block. The block receives each FIFO's occupancy as a level of `$clog2(DEPTH)+1` bits, and from that level it derives the empty and full flags. On a transmit handshake it forwards the DMA write word together with a one-cycle push strobe. On a receive handshake it pops the FIFO head and latches that head into a read-data register. Only single-word handshakes are supported. A request drops once the acknowledge has been seen, and it cannot come back until the acknowledge has been released.

Top module: `dma_fifo_requester`

## Requirements
- R1: While the transmit channel is idle, a clock edge at which `tx_dma_en` is 1 and `tx_full` is 0 sets `tx_req` to 1 after that edge. When the transmit level equals DEPTH, no transmit request is started.
- R2: While the receive channel is idle, a clock edge at which `rx_dma_en` is 1 and `rx_empty` is 0 sets `rx_req` to 1 after that edge. When the receive level is 0, no receive request is started.
- R3: Each empty flag is 1 exactly when its level input is 0. Each full flag is 1 exactly when its level equals DEPTH, which is the top bit of the level (DEPTH is a power of two). The flags follow the levels combinationally.
- R4: `tx_push` is 1 in exactly those cycles where `tx_req` and `tx_ack` are both 1. In such a cycle `tx_push_data` equals `dma_wdata`; in every other cycle it is 0.
- R5: `rx_pop` is 1 in exactly those cycles where `rx_req` and `rx_ack` are both 1. At the closing edge of that cycle `dma_rdata` takes the value of `rx_head`, and it holds that value until the next pop. Its reset value is 0.
- R6: After an edge that samples request and acknowledge both at 1, the request goes to 0. It stays at 0 until an edge samples the acknowledge at 0, and it can rise again at the earliest one edge after that.
- R7: Clearing a direction's enable bit prevents new requests in that direction. A request that is already raised stays at 1 until it is acknowledged.
- R8: An acknowledge that arrives while its request is 0 produces no strobe and leaves `dma_rdata` unchanged.
- R9: An acknowledge held for many cycles produces exactly one push or pop strobe.
- R10: While reset is active, both requests and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dma_en | input | 1 | Enables DMA requests for the transmit FIFO |
| rx_dma_en | input | 1 | Enables DMA requests for the receive FIFO |
| tx_level | input | $clog2(DEPTH)+1 | Occupancy of the transmit FIFO |
| rx_level | input | $clog2(DEPTH)+1 | Occupancy of the receive FIFO |
| tx_ack | input | 1 | DMA acknowledge for the transmit request |
| rx_ack | input | 1 | DMA acknowledge for the receive request |
| dma_wdata | input | DW | Word written by the DMA controller |
| rx_head | input | DW | Word at the head of the receive FIFO |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_push | output | 1 | One-cycle push strobe into the transmit FIFO |
| tx_push_data | output | DW | Word pushed into the transmit FIFO |
| rx_pop | output | 1 | One-cycle pop strobe from the receive FIFO |
| dma_rdata | output | DW | Last word popped, returned to the DMA controller |
| tx_empty | output | 1 | Transmit FIFO is empty |
| tx_full | output | 1 | Transmit FIFO is full |
| rx_empty | output | 1 | Receive FIFO is empty |
| rx_full | output | 1 | Receive FIFO is full |

## Verification
The bench holds an acknowledge high for several cycles. A channel that re-armed while the acknowledge was still high would issue a second push for one handshake. It also clears the enable bit while a request is pending: a design that dropped the raised request would leave the DMA controller hanging, and one that ignored the bit would keep on requesting. It drives the levels to 0 and to DEPTH, where an off-by-one in the flags starts a request into a full FIFO or out of an empty one. It also sends acknowledges while no request is raised, which a careless strobe decode would turn into spurious FIFO accesses.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  // Handshake phases of one DMA channel
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,   // waiting for a reason to ask
    CH_ASK  = 2'd1,   // request raised, waiting for acknowledge
    CH_HOLD = 2'd2    // transfer done, waiting for acknowledge release
  } ch_state_e;

  // A channel may start a request when enabled and not blocked by FIFO state
  function automatic logic launch_ok(input logic enable, input logic blocked);
    return enable & ~blocked;
  endfunction

endpackage

// File: rtl/dmareq_flags.sv
module dmareq_flags #(
  parameter int DEPTH = 64
) (
  input  logic [$clog2(DEPTH):0] level,
  output logic                   empty,
  output logic                   full
);
  localparam int AW = $clog2(DEPTH);

  // Occupancy counter carries one bit beyond the address width:
  // its top bit is set only at DEPTH entries (DEPTH is a power of two).
  assign full  = level[AW];
  assign empty = (level == '0);

endmodule

// File: rtl/dmareq_channel.sv
module dmareq_channel
  import dmareq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,   // enable and FIFO state allow a new request
  input  logic ack,
  output logic req,
  output logic xfer      // one-cycle FIFO access strobe
);

  ch_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_IDLE: if (launch) state_d = CH_ASK;
      CH_ASK:  if (ack)    state_d = CH_HOLD;
      CH_HOLD: if (!ack)   state_d = CH_IDLE;
      default:             state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  assign req  = (state_q == CH_ASK);
  assign xfer = req & ack;

endmodule

// File: rtl/dma_fifo_requester.sv
module dma_fifo_requester #(
  parameter  int DEPTH = 64,
  parameter  int DW    = 32,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_dma_en,
  input  logic          rx_dma_en,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_ack,
  input  logic          rx_ack,
  input  logic [DW-1:0] dma_wdata,
  input  logic [DW-1:0] rx_head,
  output logic          tx_req,
  output logic          rx_req,
  output logic          tx_push,
  output logic [DW-1:0] tx_push_data,
  output logic          rx_pop,
  output logic [DW-1:0] dma_rdata,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          rx_empty,
  output logic          rx_full
);

  localparam int NCH   = 2;
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;

  logic [NCH-1:0] en_v, ack_v, req_v, xfer_v;
  logic [NCH-1:0] empty_v, full_v, blocked_v, launch_v;
  logic [LW-1:0]  lvl_v [NCH];

  assign en_v         = {rx_dma_en, tx_dma_en};
  assign ack_v        = {rx_ack, tx_ack};
  assign lvl_v[CH_TX] = tx_level;
  assign lvl_v[CH_RX] = rx_level;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmareq_flags #(.DEPTH(DEPTH)) u_flags (
      .level (lvl_v[c]),
      .empty (empty_v[c]),
      .full  (full_v[c])
    );

    // transmit waits for room, receive waits for data
    if (c == CH_TX) begin : g_tx
      assign blocked_v[c] = full_v[c];
    end else begin : g_rx
      assign blocked_v[c] = empty_v[c];
    end

    assign launch_v[c] = dmareq_pkg::launch_ok(en_v[c], blocked_v[c]);

    dmareq_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch_v[c]),
      .ack    (ack_v[c]),
      .req    (req_v[c]),
      .xfer   (xfer_v[c])
    );
  end

  // Popped word is held for the DMA read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dma_rdata <= '0;
    else if (xfer_v[CH_RX]) dma_rdata <= rx_head;
  end

  assign tx_req       = req_v[CH_TX];
  assign rx_req       = req_v[CH_RX];
  assign tx_push      = xfer_v[CH_TX];
  assign rx_pop       = xfer_v[CH_RX];
  assign tx_push_data = xfer_v[CH_TX] ? dma_wdata : '0;
  assign tx_empty     = empty_v[CH_TX];
  assign tx_full      = full_v[CH_TX];
  assign rx_empty     = empty_v[CH_RX];
  assign rx_full      = full_v[CH_RX];

endmodule

// File: rtl/dma_fifo_requester_chk.sv
module dma_fifo_requester_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_dma_en,
  input logic          rx_dma_en,
  input logic          tx_full,
  input logic          rx_empty,
  input logic          tx_ack,
  input logic          rx_ack,
  input logic          tx_req,
  input logic          rx_req,
  input logic          tx_push,
  input logic          rx_pop,
  input logic [DW-1:0] rx_head,
  input logic [DW-1:0] dma_rdata
);

  AST_TX_REQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> ($past(tx_dma_en) && !$past(tx_full))); // R1

  AST_RX_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req) |-> ($past(rx_dma_en) && !$past(rx_empty))); // R2

  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> (dma_rdata == $past(rx_head))); // R5

  AST_TX_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_ack) |=> !tx_req); // R6

  AST_RX_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_ack) |=> !rx_req); // R6

  AST_TX_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ack) |=> tx_req); // R7

  AST_RX_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !rx_ack) |=> rx_req); // R7

  AST_TX_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push); // R9

  AST_RX_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop); // R9

endmodule

bind dma_fifo_requester dma_fifo_requester_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_dma_en (tx_dma_en),
  .rx_dma_en (rx_dma_en),
  .tx_full   (tx_full),
  .rx_empty  (rx_empty),
  .tx_ack    (tx_ack),
  .rx_ack    (rx_ack),
  .tx_req    (tx_req),
  .rx_req    (rx_req),
  .tx_push   (tx_push),
  .rx_pop    (rx_pop),
  .rx_head   (rx_head),
  .dma_rdata (dma_rdata)
);

// File: tb/tb_dma_fifo_requester.sv
module tb_dma_fifo_requester;
  localparam int DEPTH = 64;
  localparam int DW    = 32;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          tx_en = 1'b0, rx_en = 1'b0, tx_ack = 1'b0, rx_ack = 1'b0;
  logic [LW-1:0] tx_lvl = '0, rx_lvl = '0;
  logic [DW-1:0] wdata = '0, head = '0;
  logic          tx_req, rx_req, tx_push, rx_pop;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [DW-1:0] tx_push_data, dma_rdata;

  dma_fifo_requester #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .tx_dma_en(tx_en), .rx_dma_en(rx_en),
    .tx_level(tx_lvl), .rx_level(rx_lvl), .tx_ack(tx_ack), .rx_ack(rx_ack),
    .dma_wdata(wdata), .rx_head(head), .tx_req(tx_req), .rx_req(rx_req),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .rx_pop(rx_pop),
    .dma_rdata(dma_rdata), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_full(rx_full)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  int  dut_push_cnt = 0, dut_pop_cnt = 0;

  // Behavioural reference: "asking" and "waiting for release" per direction
  bit            t_asking = 0, t_spent = 0, r_asking = 0, r_spent = 0;
  logic [DW-1:0] r_word = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_asking = 0; t_spent = 0; r_asking = 0; r_spent = 0; r_word = '0;
    end else begin
      if (t_asking) begin
        if (tx_ack) begin t_asking = 0; t_spent = 1; end
      end else if (t_spent) begin
        if (!tx_ack) t_spent = 0;
      end else begin
        t_asking = tx_en && (int'(tx_lvl) < DEPTH);
      end
      if (r_asking) begin
        if (rx_ack) begin r_asking = 0; r_spent = 1; r_word = head; end
      end else if (r_spent) begin
        if (!rx_ack) r_spent = 0;
      end else begin
        r_asking = rx_en && (int'(rx_lvl) > 0);
      end
    end
  end

  // Compare every cycle, mid-cycle
  always @(negedge clk) begin
    if (!done) begin
      if (tx_push) dut_push_cnt++;
      if (rx_pop)  dut_pop_cnt++;
      if (!rst_n) begin
        chk("R10 tx_req in reset", tx_req, 0);
        chk("R10 rx_req in reset", rx_req, 0);
      end
      chk("R1 tx_req", tx_req, t_asking);
      chk("R2 rx_req", rx_req, r_asking);
      chk("R3 tx_empty", tx_empty, tx_lvl == 0);
      chk("R3 tx_full",  tx_full,  int'(tx_lvl) == DEPTH);
      chk("R3 rx_empty", rx_empty, rx_lvl == 0);
      chk("R3 rx_full",  rx_full,  int'(rx_lvl) == DEPTH);
      chk("R4 tx_push", tx_push, t_asking && tx_ack);
      chk("R4 tx_push_data", tx_push_data, (t_asking && tx_ack) ? wdata : '0);
      chk("R5 rx_pop", rx_pop, r_asking && rx_ack);
      chk("R5 dma_rdata", dma_rdata, r_word);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int pc;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 boundary: full FIFO never starts a transmit request
    tx_en = 1; tx_lvl = LW'(DEPTH);
    step(3);
    @(negedge clk); chk("R1 no request when full", tx_req, 0);
    step(); tx_lvl = LW'(DEPTH - 1);
    step(2);
    @(negedge clk); chk("R1 request at DEPTH-1", tx_req, 1);

    // R6/R9: acknowledge held for four cycles
    step(); pc = dut_push_cnt; wdata = 32'hCAFE_0001; tx_ack = 1;
    step(2);
    @(negedge clk); chk("R6 request low while ack held", tx_req, 0);
    step(2); tx_ack = 0; wdata = '0;
    step(3);
    chk("R9 one push per handshake", 64'(dut_push_cnt - pc), 1);

    // R7: clearing enable keeps a pending request, blocks the next one
    tx_lvl = 10;
    step(2);
    @(negedge clk); chk("R7 request raised", tx_req, 1);
    step(); tx_en = 0;
    step(3);
    @(negedge clk); chk("R7 raised request held", tx_req, 1);
    step(); tx_ack = 1;
    step(); tx_ack = 0;
    step(4);
    @(negedge clk); chk("R7 no new request", tx_req, 0);

    // R2 boundary: empty FIFO never starts a receive request
    step(); rx_en = 1; rx_lvl = 0;
    step(3);
    @(negedge clk); chk("R2 no request when empty", rx_req, 0);
    step(); rx_lvl = 5;
    step(2);
    @(negedge clk); chk("R2 request with data", rx_req, 1);
    step(); head = 32'hA5A5_5A5A; rx_ack = 1;
    step(); rx_ack = 0; head = 32'h1111_2222;
    @(negedge clk); chk("R5 read word captured", dma_rdata, 32'hA5A5_5A5A);

    // R8: stray acknowledges with no request raised
    step(); rx_en = 0; rx_lvl = 0; tx_en = 0;
    step(3); pc = dut_pop_cnt + dut_push_cnt;
    tx_ack = 1; rx_ack = 1; head = 32'hDEAD_BEEF; wdata = 32'h7777_0000;
    step(2); tx_ack = 0; rx_ack = 0;
    step(2);
    chk("R8 no strobe on stray ack", 64'(dut_pop_cnt + dut_push_cnt - pc), 0);
    @(negedge clk); chk("R8 read word unchanged", dma_rdata, 32'hA5A5_5A5A);

    // Mixed traffic against the reference model
    step();
    for (int i = 0; i < 800; i++) begin
      tx_en  = ($urandom_range(0, 9) != 0);
      rx_en  = ($urandom_range(0, 9) != 0);
      tx_ack = ($urandom_range(0, 2) == 0);
      rx_ack = ($urandom_range(0, 2) == 0);
      tx_lvl = ($urandom_range(0, 3) == 0) ? LW'(DEPTH) : LW'($urandom_range(0, DEPTH));
      rx_lvl = ($urandom_range(0, 3) == 0) ? '0 : LW'($urandom_range(0, DEPTH));
      wdata  = $urandom;
      head   = $urandom;
      step();
    end

    // R10: reset mid-traffic returns to idle
    tx_en = 1; tx_lvl = 3; step(2);
    rst_n = 0; step(2);
    rst_n = 1; tx_en = 0; step(3);
    finish_run();
  end

endmodule